// File: doc/BRIEF.md
# I2C Control Register with Bus-Error Detection

This block holds the software-visible control byte of an I2C interface and watches the bus for misplaced START and STOP conditions. Software sets the control fields through a small write/read port. Logic further down the chip uses the stored fields: the start request, master select, data-acknowledge enable and general-call acknowledge enable. The block keeps two flags, a bus-error flag and a transfer-complete flag, and drives one interrupt request for each of them.

SCL and SDA pass through a two-stage synchronizer. A condition monitor then tracks the bus. It counts bits between conditions and reports a START or STOP that arrives in the middle of a byte. Such an error sets the error flag and clears the interface enable, which lives at a second address. Clearing the enable stops the transfer in progress. Only a software write sets the enable again.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset the control byte reads 0x00, the enable register reads 0x00, and both interrupt requests are low.
- R2: Address 0 is the control byte. Bit 7 is the error flag, bit 6 the error interrupt enable, bit 5 the start request, bit 4 master select, bit 3 data-ack enable, bit 2 general-call ack enable, bit 1 the transfer interrupt enable and bit 0 the transfer flag. Bits 6..1 store written values and read them back, and bits 5..2 also appear on their output ports. Address 1 holds the interface enable in bit 0 and reads 0 in bits 7..1.
- R3: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Either one is legal when the bus is idle or when no bit of the current byte has completed, so it does not set the error flag.
- R4: The bit counter restarts at a START and counts SCL falling edges, ignoring the first fall after the START. It wraps to zero after nine bits. A START or STOP seen while the counter is between 1 and 8 sets the error flag.
- R5: berr_irq is high exactly while the error flag and the error interrupt enable are both 1.
- R6: Writing 0 to bit 7 clears the error flag. Writing 1 to bit 7 leaves the flag unchanged.
- R7: A read with rmw high returns 1 in bit 7 whatever the flag holds, and the true values in bits 6..0. A read with rmw low returns the true flag.
- R8: Setting the error flag forces the interface enable to 0 in the same cycle. The enable returns to 1 only when software writes 1 to address 1.
- R9: If an error is detected in the same cycle that software writes 0 to bit 7, the flag ends up set.
- R10: A pulse on xfer_done sets bit 0. Writing 0 to bit 0 clears it, and writing 1 leaves it unchanged. xfer_irq is high exactly while bits 0 and 1 are both 1.
- R11: Misplaced conditions do not set the error flag while the interface enable is 0.
- R12: A START, then a full nine-bit byte, then a repeated START or a STOP, produces no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| addr | input | 1 | Register select: 0 control byte, 1 enable |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rmw | input | 1 | Marks the read as part of a read-modify-write access |
| rd_data | output | 8 | Combinational read data for addr |
| xfer_done | input | 1 | One-cycle transfer-complete event |
| if_en | output | 1 | Interface enable |
| start_req | output | 1 | Stored start request |
| master_sel | output | 1 | Stored master select |
| data_ack_en | output | 1 | Stored data-acknowledge enable |
| gcall_ack_en | output | 1 | Stored general-call acknowledge enable |
| berr_irq | output | 1 | Bus-error interrupt request |
| xfer_irq | output | 1 | Transfer interrupt request |

## Verification
Error detection is tried with five bus patterns:
- A START followed at once by a STOP.
- A complete nine-bit byte closed by a repeated START and a STOP.
- A STOP after three bits.
- A repeated START after two bits.
- A misplaced condition while the interface is disabled.

The first two patterns show the counter accepting conditions at a byte boundary. The next two show it rejecting conditions inside a byte. The last shows the gating by the enable. Register access is walked through a table of write values with and without rmw, which separates real storage from the forced read bit and from the write-1-ignored flags. Timed cases then cover a hardware set that collides with a software clear, and the interrupt gating of each flag.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

    localparam int unsigned REG_W = 8;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_EN   = 1'b1;

    // Control byte, most significant field first (bit 7 down to bit 0).
    typedef struct packed {
        logic berr_flag;
        logic berr_ie;
        logic start_req;
        logic master_sel;
        logic data_ack_en;
        logic gcall_ack_en;
        logic xfer_ie;
        logic xfer_flag;
    } ctrl_t;

    typedef struct packed {
        ctrl_t ctrl;
        logic  en;
    } regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_single
            assign chain_d = d_in;
        end else begin : g_multi
            assign chain_d = {chain_q[STAGES-2:0], d_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor #(
    parameter int unsigned BYTE_BITS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic bad_cond
);
    localparam int unsigned CNT_W = $clog2(BYTE_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

    typedef struct packed {
        logic             prev_scl;
        logic             prev_sda;
        logic             idle;
        logic             skip;
        logic [CNT_W-1:0] cnt;
    } mon_t;

    mon_t mon_d, mon_q;
    logic start_ev, stop_ev, scl_fall, legal;

    always_comb begin
        start_ev = scl && mon_q.prev_scl && mon_q.prev_sda && !sda;
        stop_ev  = scl && mon_q.prev_scl && !mon_q.prev_sda && sda;
        scl_fall = mon_q.prev_scl && !scl;
        legal    = mon_q.idle || (mon_q.cnt == '0);
        bad_cond = (start_ev || stop_ev) && !legal;

        mon_d          = mon_q;
        mon_d.prev_scl = scl;
        mon_d.prev_sda = sda;
        if (stop_ev) begin
            mon_d.idle = 1'b1;
            mon_d.skip = 1'b0;
            mon_d.cnt  = '0;
        end else if (start_ev) begin
            mon_d.idle = 1'b0;
            mon_d.skip = 1'b1;
            mon_d.cnt  = '0;
        end else if (scl_fall && !mon_q.idle) begin
            if (mon_q.skip)               mon_d.skip = 1'b0;
            else if (mon_q.cnt == CNT_LAST) mon_d.cnt = '0;
            else                          mon_d.cnt = mon_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '{prev_scl: 1'b1, prev_sda: 1'b1, idle: 1'b1, skip: 1'b0, cnt: '0};
        else        mon_q <= mon_d;
    end

    // R4: counter never leaves its nine-state range
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mon_q.cnt <= CNT_LAST);

    // R3: a STOP always returns the monitor to idle
    p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> mon_q.idle);
endmodule

// File: rtl/i2c_ctl_regfile.sv
module i2c_ctl_regfile
    import i2c_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rmw,
    input  logic             xfer_done,
    input  logic             bad_cond,
    output logic [REG_W-1:0] rd_data,
    output regs_t            regs
);
    regs_t regs_d, regs_q;
    ctrl_t wr_ctrl;
    logic  err_set;

    always_comb begin
        wr_ctrl = ctrl_t'(wr_data);
        err_set = bad_cond && regs_q.en;

        regs_d = regs_q;
        if (wr_en && addr == ADDR_CTRL) begin
            regs_d.ctrl.berr_ie      = wr_ctrl.berr_ie;
            regs_d.ctrl.start_req    = wr_ctrl.start_req;
            regs_d.ctrl.master_sel   = wr_ctrl.master_sel;
            regs_d.ctrl.data_ack_en  = wr_ctrl.data_ack_en;
            regs_d.ctrl.gcall_ack_en = wr_ctrl.gcall_ack_en;
            regs_d.ctrl.xfer_ie      = wr_ctrl.xfer_ie;
            if (!wr_ctrl.berr_flag) regs_d.ctrl.berr_flag = 1'b0;
            if (!wr_ctrl.xfer_flag) regs_d.ctrl.xfer_flag = 1'b0;
        end
        if (wr_en && addr == ADDR_EN) regs_d.en = wr_data[0];
        if (xfer_done) regs_d.ctrl.xfer_flag = 1'b1;
        if (err_set) begin
            regs_d.ctrl.berr_flag = 1'b1;
            regs_d.en             = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (addr == ADDR_CTRL) begin
            rd_data    = regs_q.ctrl;
            rd_data[7] = regs_q.ctrl.berr_flag | rmw;
        end else begin
            rd_data = {{(REG_W-1){1'b0}}, regs_q.en};
        end
    end

    assign regs = regs_q;

    // R8: the error flag rising leaves the interface disabled
    p_err_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.ctrl.berr_flag) |-> !regs_q.en);

    // R11: the flag can only rise out of an enabled interface
    p_err_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.ctrl.berr_flag) |-> $past(regs_q.en));

    // R9: a detected error always lands, whatever software writes
    p_err_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> regs_q.ctrl.berr_flag);

    // R6: without a hardware event the flag only falls on a written 0
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl.berr_flag && !(wr_en && addr == ADDR_CTRL && !wr_data[7]))
        |=> regs_q.ctrl.berr_flag);

    // R10: a transfer-complete pulse sets the flag
    p_xfer_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> regs_q.ctrl.xfer_flag);
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
    import i2c_ctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BYTE_BITS   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             addr,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rmw,
    output logic [REG_W-1:0] rd_data,
    input  logic             xfer_done,
    output logic             if_en,
    output logic             start_req,
    output logic             master_sel,
    output logic             data_ack_en,
    output logic             gcall_ack_en,
    output logic             berr_irq,
    output logic             xfer_irq
);
    logic  scl_s, sda_s, bad_cond;
    regs_t regs;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_in(scl_in), .d_out(scl_s));
    i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_in(sda_in), .d_out(sda_s));

    i2c_cond_monitor #(.BYTE_BITS(BYTE_BITS)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s), .bad_cond(bad_cond));

    i2c_ctl_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rmw(rmw), .xfer_done(xfer_done), .bad_cond(bad_cond),
        .rd_data(rd_data), .regs(regs));

    assign if_en        = regs.en;
    assign start_req    = regs.ctrl.start_req;
    assign master_sel   = regs.ctrl.master_sel;
    assign data_ack_en  = regs.ctrl.data_ack_en;
    assign gcall_ack_en = regs.ctrl.gcall_ack_en;
    assign berr_irq     = regs.ctrl.berr_flag & regs.ctrl.berr_ie;
    assign xfer_irq     = regs.ctrl.xfer_flag & regs.ctrl.xfer_ie;

    // R5: the error request never appears without its flag
    p_berr_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        berr_irq |-> rd_data[7] || addr != ADDR_CTRL || rmw);
endmodule

// File: tb/i2c_ctl_reg_bench.sv
module i2c_ctl_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       addr = 1'b0, wr_en = 1'b0, rmw = 1'b0, xfer_done = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       if_en, start_req, master_sel, data_ack_en, gcall_ack_en, berr_irq, xfer_irq;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    i2c_ctl_reg u_i2c_ctl_reg (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rmw(rmw), .rd_data(rd_data),
        .xfer_done(xfer_done), .if_en(if_en), .start_req(start_req),
        .master_sel(master_sel), .data_ack_en(data_ack_en), .gcall_ack_en(gcall_ack_en),
        .berr_irq(berr_irq), .xfer_irq(xfer_irq));

    // {write value, rmw, expected read}
    localparam logic [16:0] VECS [7] = '{
        {8'h7F, 1'b0, 8'h7E},
        {8'h00, 1'b0, 8'h00},
        {8'hFF, 1'b0, 8'h7E},
        {8'h00, 1'b1, 8'h80},
        {8'h55, 1'b0, 8'h54},
        {8'hAA, 1'b1, 8'hAA},
        {8'h3C, 1'b0, 8'h3C}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, input logic m, output logic [7:0] v);
        @(negedge clk);
        addr = a; rmw = m;
        #1 v = rd_data;
        rmw = 1'b0;
    endtask

    task automatic line(input logic c, input logic d);
        @(negedge clk);
        scl_in = c; sda_in = d;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_start();
        line(1'b0, 1'b1); line(1'b1, 1'b1); line(1'b1, 1'b0); line(1'b0, 1'b0);
    endtask

    task automatic do_stop();
        line(1'b0, 1'b0); line(1'b1, 1'b0); line(1'b1, 1'b1);
    endtask

    task automatic send_bit(input logic b);
        line(1'b0, b); line(1'b1, b); line(1'b0, b);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, 1'b0, v); check("R1 ctrl", v, 8'h00);
        rd(1'b1, 1'b0, v); check("R1 enable", v, 8'h00);
        check("R1 irqs", {6'b0, berr_irq, xfer_irq}, 8'h00);

        // R2 R6 R7 R10: register table
        foreach (VECS[i]) begin
            wr(1'b0, VECS[i][16:9]);
            rd(1'b0, VECS[i][8], v);
            check($sformatf("R2/R6/R7/R10 vec%0d", i), v, VECS[i][7:0]);
        end
        check("R2 field ports", {4'b0, start_req, master_sel, data_ack_en, gcall_ack_en}, 8'h0F);
        rd(1'b0, 1'b0, v); check("R7 plain read", v, 8'h3C);

        // R8 software enable
        wr(1'b1, 8'hFF); rd(1'b1, 1'b0, v); check("R2/R8 enable write", v, 8'h01);
        wr(1'b0, 8'h40);

        // R3 legal START then STOP
        do_start(); do_stop();
        rd(1'b0, 1'b0, v); check("R3 legal start/stop", v, 8'h40);

        // R12 full byte, repeated START, STOP
        do_start();
        for (int b = 0; b < 9; b++) send_bit(b[0]);
        do_start(); do_stop();
        rd(1'b0, 1'b0, v); check("R12 full byte", v, 8'h40);

        // R4 STOP after three bits
        do_start();
        for (int b = 0; b < 3; b++) send_bit(1'b1);
        do_stop();
        rd(1'b0, 1'b0, v); check("R4 mid-byte stop", v, 8'hC0);
        check("R8 enable cleared", {7'b0, if_en}, 8'h00);
        check("R5 irq both set", {7'b0, berr_irq}, 8'h01);
        rd(1'b0, 1'b1, v); check("R7 rmw with flag", v, 8'hC0);

        // R6 R5 write paths on the flag
        wr(1'b0, 8'hC0); rd(1'b0, 1'b0, v); check("R6 write 1 ignored", v, 8'hC0);
        wr(1'b0, 8'h80); rd(1'b0, 1'b0, v); check("R5 ie cleared", v, 8'h80);
        check("R5 irq masked", {7'b0, berr_irq}, 8'h00);
        wr(1'b0, 8'h00); rd(1'b0, 1'b0, v); check("R6 clear", v, 8'h00);

        // R11 no detection while disabled
        do_start(); send_bit(1'b0); send_bit(1'b1);
        line(1'b0, 1'b1); line(1'b1, 1'b1); line(1'b1, 1'b0); line(1'b0, 1'b0);
        do_stop();
        rd(1'b0, 1'b0, v); check("R11 suppressed", v, 8'h00);

        // R4 R5 mid-byte repeated START with interrupt disabled
        wr(1'b1, 8'h01); check("R8 re-enable", {7'b0, if_en}, 8'h01);
        do_start(); send_bit(1'b0); send_bit(1'b1);
        line(1'b0, 1'b1); line(1'b1, 1'b1); line(1'b1, 1'b0);
        rd(1'b0, 1'b0, v); check("R4 mid-byte start", v, 8'h80);
        check("R5 irq off without ie", {7'b0, berr_irq}, 8'h00);
        line(1'b0, 1'b0); do_stop();
        wr(1'b0, 8'h00);

        // R9 hardware set against software clear in the same cycle
        wr(1'b1, 8'h01);
        do_start(); send_bit(1'b0);
        line(1'b0, 1'b0); line(1'b1, 1'b0);
        @(negedge clk); sda_in = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 1'b0; wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        repeat (4) @(negedge clk);
        rd(1'b0, 1'b0, v); check("R9 hw set wins", v, 8'h80);
        check("R9/R8 enable off", {7'b0, if_en}, 8'h00);
        wr(1'b0, 8'h00);

        // R10 transfer flag and interrupt
        wr(1'b0, 8'h02);
        @(negedge clk); xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
        rd(1'b0, 1'b0, v); check("R10 set by pulse", v, 8'h03);
        check("R10 irq", {7'b0, xfer_irq}, 8'h01);
        wr(1'b0, 8'h03); rd(1'b0, 1'b0, v); check("R10 write 1 ignored", v, 8'h03);
        wr(1'b0, 8'h02); rd(1'b0, 1'b0, v); check("R10 clear", v, 8'h02);
        check("R10 irq cleared", {7'b0, xfer_irq}, 8'h00);
        wr(1'b0, 8'h00);
        @(negedge clk); xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
        rd(1'b0, 1'b0, v); check("R10 flag without ie", v, 8'h01);
        check("R10 irq masked", {7'b0, xfer_irq}, 8'h00);

        finish_run();
    end
endmodule